// File: doc/BRIEF.md
# Contended-lock limiter identifier

This block watches lock traffic from a group of threads and names one thread that is most likely holding up the rest. It keeps a small table of lock addresses. For every lock in the table it adds up, cycle by cycle, how many threads are blocked on that lock. When a fixed-length interval ends, it takes the lock with the largest total. The thread that owns that lock at that moment becomes the reported limiter thread. A memory request scheduler reads the limiter ID and its valid flag and gives that thread's requests a higher priority.

Each thread has its own wait-begin and wait-end strobes and a lock address bus. Ownership arrives on one acquire port, which carries a lock address and the owner's thread ID, and on one release port, which carries a lock address. Table entries are only created by an acquire. Waits on addresses that are not in the table are not counted. The limiter output changes only at interval ends and holds its value in between.

Top module: `lim_limiter_id`

## Requirements
- R1: During reset and until the end of the first interval, `limiter_valid_o` is 0 and `limiter_tid_o` is 0.
- R2: On every clock edge, each table entry's running total grows by the number of threads currently in the waiting state on that entry. A wait whose begin strobe is sampled at edge k and whose end strobe is sampled at edge k+n contributes n.
- R3: An interval is `LEN` clock edges long, counted from reset release. The limiter outputs are updated only on the last edge of each interval and otherwise hold their value.
- R4: The selected lock is the entry with the strictly largest total. Ties go to the lowest table index. Entries are allocated at the lowest free index.
- R5: If every total is zero at the interval end, `limiter_valid_o` becomes 0. Whenever `limiter_valid_o` is 0, `limiter_tid_o` reads 0.
- R6: When there is a winning entry, `limiter_tid_o` takes that entry's owner thread ID. If the winning entry has no owner at that edge, the valid flag becomes 0 and the ID becomes 0.
- R7: All totals restart from zero after each interval end, so waits in one interval have no effect on the next interval's choice.
- R8: An acquire of an address that is not in the table takes the lowest free entry. If no entry is free, the acquire is ignored. A wait-begin on an address that is not in the table leaves the thread not counted for the whole of that wait.
- R9: A release clears the owner of the matching entry. An acquire of an address already in the table replaces the owner. If an acquire and a release name the same lock on the same edge, the acquire wins.
- R10: At an interval end, an entry with no owner, no waiting thread and no acquire or wait-begin on that edge is freed, and its address stops being counted.
- R11: If a thread's wait-end and wait-begin strobes are sampled on the same edge, the begin wins and the thread stays waiting on the newly named lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wait_begin_i | input | NT | Per-thread strobe: the thread starts waiting on the lock named on its address lane |
| wait_end_i | input | NT | Per-thread strobe: the thread stops waiting |
| wait_addr_i | input | NT*AW | Per-thread lock address; thread t uses bits [t*AW +: AW] |
| acq_valid_i | input | 1 | A lock is acquired this cycle |
| acq_addr_i | input | AW | Address of the acquired lock |
| acq_tid_i | input | TW | Thread ID of the new owner |
| rel_valid_i | input | 1 | A lock is released this cycle |
| rel_addr_i | input | AW | Address of the released lock |
| limiter_valid_o | output | 1 | A limiter thread is reported |
| limiter_tid_o | output | TW | Thread ID of the limiter |

## Verification
Internal state shows at the ports only at interval ends, so every internal error is hidden for up to `LEN` cycles. Some examples: a counter that misses or double-counts a waiter, a stale owner, or an entry freed too early or too late. The bench therefore compares the outputs with a cycle-level model on every cycle. It also uses directed intervals in which a single fault changes which thread wins: a lost wait makes a different lock win, a wrong tie rule picks the other owner, and a missing clear keeps an empty interval valid. An error that survives an interval end, such as a table entry that was never freed, shows only when a later interval's choice depends on that entry. That can be several intervals later.

// File: rtl/lim_pkg.sv
package lim_pkg;

    localparam int unsigned DEF_THREADS  = 4;
    localparam int unsigned DEF_ENTRIES  = 4;
    localparam int unsigned DEF_ADDR_W   = 16;
    localparam int unsigned DEF_INTERVAL = 64;

    // index width that stays at least one bit
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lim_lock_table.sv
module lim_lock_table
    import lim_pkg::*;
#(
    parameter int unsigned NE = DEF_ENTRIES,
    parameter int unsigned NT = DEF_THREADS,
    parameter int unsigned AW = DEF_ADDR_W,
    parameter int unsigned TW = idx_w(NT),
    parameter int unsigned IW = idx_w(NE)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   boundary_i,
    input  logic                   acq_valid_i,
    input  logic [AW-1:0]          acq_addr_i,
    input  logic [TW-1:0]          acq_tid_i,
    input  logic                   rel_valid_i,
    input  logic [AW-1:0]          rel_addr_i,
    input  logic [NT-1:0][AW-1:0]  probe_addr_i,
    input  logic [NE-1:0]          busy_i,
    output logic [NT-1:0]          probe_hit_o,
    output logic [NT-1:0][IW-1:0]  probe_idx_o,
    output logic [NE-1:0]          held_o,
    output logic [NE-1:0][TW-1:0]  owner_o
);

    typedef struct packed {
        logic [NE-1:0]         used;
        logic [NE-1:0]         held;
        logic [NE-1:0][AW-1:0] addr;
        logic [NE-1:0][TW-1:0] owner;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    // returns {hit, index} of the entry holding address a
    function automatic logic [IW:0] lookup(input logic [AW-1:0] a);
        logic [IW:0] r;
        r = '0;
        for (int e = NE - 1; e >= 0; e--) begin
            if (tbl_q.used[e] && tbl_q.addr[e] == a) r = {1'b1, IW'(e)};
        end
        return r;
    endfunction

    logic          acq_hit, rel_hit, free_ok;
    logic [IW-1:0] acq_idx, rel_idx, free_idx;

    for (genvar t = 0; t < NT; t++) begin : g_probe
        always_comb begin
            {probe_hit_o[t], probe_idx_o[t]} = lookup(probe_addr_i[t]);
        end
    end

    always_comb begin
        {acq_hit, acq_idx} = lookup(acq_addr_i);
        {rel_hit, rel_idx} = lookup(rel_addr_i);
        free_ok  = 1'b0;
        free_idx = '0;
        for (int e = NE - 1; e >= 0; e--) begin
            if (!tbl_q.used[e]) begin
                free_ok  = 1'b1;
                free_idx = IW'(e);
            end
        end

        tbl_d = tbl_q;
        if (rel_valid_i && rel_hit && !(acq_valid_i && acq_hit && acq_idx == rel_idx))
            tbl_d.held[rel_idx] = 1'b0;
        if (acq_valid_i) begin
            if (acq_hit) begin
                tbl_d.held[acq_idx]  = 1'b1;
                tbl_d.owner[acq_idx] = acq_tid_i;
            end else if (free_ok) begin
                tbl_d.used[free_idx]  = 1'b1;
                tbl_d.held[free_idx]  = 1'b1;
                tbl_d.addr[free_idx]  = acq_addr_i;
                tbl_d.owner[free_idx] = acq_tid_i;
            end
        end
        if (boundary_i) begin
            for (int e = 0; e < NE; e++) begin
                if (tbl_q.used[e] && !tbl_q.held[e] && !busy_i[e] &&
                    !(acq_valid_i && acq_hit && acq_idx == IW'(e)))
                    tbl_d.used[e] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign held_o  = tbl_q.held;
    assign owner_o = tbl_q.owner;

endmodule

// File: rtl/lim_wait_track.sv
module lim_wait_track
    import lim_pkg::*;
#(
    parameter int unsigned NT = DEF_THREADS,
    parameter int unsigned NE = DEF_ENTRIES,
    parameter int unsigned IW = idx_w(NE),
    parameter int unsigned CW = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  boundary_i,
    input  logic [NT-1:0]         begin_i,
    input  logic [NT-1:0]         end_i,
    input  logic [NT-1:0]         hit_i,
    input  logic [NT-1:0][IW-1:0] idx_i,
    output logic [NE-1:0][CW-1:0] total_o,
    output logic [NE-1:0]         busy_o
);

    typedef struct packed {
        logic [NT-1:0]         act;
        logic [NT-1:0][IW-1:0] idx;
        logic [NE-1:0][CW-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        for (int e = 0; e < NE; e++) begin
            logic [CW-1:0] n;
            logic          starting;
            n        = '0;
            starting = 1'b0;
            for (int t = 0; t < NT; t++) begin
                if (trk_q.act[t] && trk_q.idx[t] == IW'(e)) n = n + CW'(1);
                if (begin_i[t] && hit_i[t] && idx_i[t] == IW'(e)) starting = 1'b1;
            end
            total_o[e]     = trk_q.cnt[e] + n;
            busy_o[e]      = (n != '0) || starting;
            trk_d.cnt[e]   = boundary_i ? '0 : total_o[e];
        end
        for (int t = 0; t < NT; t++) begin
            if (end_i[t]) trk_d.act[t] = 1'b0;
            if (begin_i[t] && hit_i[t]) begin
                trk_d.act[t] = 1'b1;
                trk_d.idx[t] = idx_i[t];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

endmodule

// File: rtl/lim_max_select.sv
module lim_max_select
    import lim_pkg::*;
#(
    parameter int unsigned NE = DEF_ENTRIES,
    parameter int unsigned CW = 9,
    parameter int unsigned IW = idx_w(NE)
) (
    input  logic [NE-1:0][CW-1:0] total_i,
    output logic [IW-1:0]         best_idx_o,
    output logic [CW-1:0]         best_val_o
);

    // strict comparison keeps the lowest index on ties
    always_comb begin
        best_idx_o = '0;
        best_val_o = total_i[0];
        for (int e = 1; e < NE; e++) begin
            if (total_i[e] > best_val_o) begin
                best_val_o = total_i[e];
                best_idx_o = IW'(e);
            end
        end
    end

endmodule

// File: rtl/lim_limiter_id.sv
module lim_limiter_id
    import lim_pkg::*;
#(
    parameter int unsigned NT  = DEF_THREADS,
    parameter int unsigned NE  = DEF_ENTRIES,
    parameter int unsigned AW  = DEF_ADDR_W,
    parameter int unsigned LEN = DEF_INTERVAL,
    localparam int unsigned TW = idx_w(NT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NT-1:0]     wait_begin_i,
    input  logic [NT-1:0]     wait_end_i,
    input  logic [NT*AW-1:0]  wait_addr_i,
    input  logic              acq_valid_i,
    input  logic [AW-1:0]     acq_addr_i,
    input  logic [TW-1:0]     acq_tid_i,
    input  logic              rel_valid_i,
    input  logic [AW-1:0]     rel_addr_i,
    output logic              limiter_valid_o,
    output logic [TW-1:0]     limiter_tid_o
);

    localparam int unsigned IW = idx_w(NE);
    localparam int unsigned CW = $clog2(LEN * NT + 1);
    localparam int unsigned KW = idx_w(LEN);

    typedef struct packed {
        logic [KW-1:0] tick;
        logic          lim_v;
        logic [TW-1:0] lim_t;
    } top_t;

    top_t top_d, top_q;

    logic                  boundary;
    logic [NT-1:0]         hit;
    logic [NT-1:0][IW-1:0] hit_idx;
    logic [NE-1:0]         busy;
    logic [NE-1:0]         held;
    logic [NE-1:0][TW-1:0] owner;
    logic [NE-1:0][CW-1:0] total;
    logic [IW-1:0]         best_idx;
    logic [CW-1:0]         best_val;

    assign boundary = (top_q.tick == KW'(LEN - 1));

    lim_lock_table #(.NE(NE), .NT(NT), .AW(AW), .TW(TW), .IW(IW)) table_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .boundary_i   (boundary),
        .acq_valid_i  (acq_valid_i),
        .acq_addr_i   (acq_addr_i),
        .acq_tid_i    (acq_tid_i),
        .rel_valid_i  (rel_valid_i),
        .rel_addr_i   (rel_addr_i),
        .probe_addr_i (wait_addr_i),
        .busy_i       (busy),
        .probe_hit_o  (hit),
        .probe_idx_o  (hit_idx),
        .held_o       (held),
        .owner_o      (owner)
    );

    lim_wait_track #(.NT(NT), .NE(NE), .IW(IW), .CW(CW)) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (boundary),
        .begin_i    (wait_begin_i),
        .end_i      (wait_end_i),
        .hit_i      (hit),
        .idx_i      (hit_idx),
        .total_o    (total),
        .busy_o     (busy)
    );

    lim_max_select #(.NE(NE), .CW(CW), .IW(IW)) select_i (
        .total_i    (total),
        .best_idx_o (best_idx),
        .best_val_o (best_val)
    );

    always_comb begin
        top_d      = top_q;
        top_d.tick = boundary ? '0 : top_q.tick + KW'(1);
        if (boundary) begin
            if (best_val != '0 && held[best_idx]) begin
                top_d.lim_v = 1'b1;
                top_d.lim_t = owner[best_idx];
            end else begin
                top_d.lim_v = 1'b0;
                top_d.lim_t = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign limiter_valid_o = top_q.lim_v;
    assign limiter_tid_o   = top_q.lim_t;

endmodule

// File: rtl/lim_limiter_id_chk.sv
module lim_limiter_id_chk
    import lim_pkg::*;
#(
    parameter int unsigned NT  = DEF_THREADS,
    parameter int unsigned LEN = DEF_INTERVAL,
    localparam int unsigned TW = idx_w(NT)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NT-1:0] wait_begin_i,
    input logic [NT-1:0] wait_end_i,
    input logic          acq_valid_i,
    input logic [TW-1:0] acq_tid_i,
    input logic          limiter_valid_o,
    input logic [TW-1:0] limiter_tid_o
);

    localparam int unsigned KW = idx_w(LEN);

    logic [KW-1:0] tick_q;
    logic          first_q;
    logic          quiet_q;
    logic [NT-1:0] maybe_wait_q;
    logic [NT-1:0] seen_q;
    logic          bnd;

    assign bnd = (tick_q == KW'(LEN - 1));

    // over-approximation of which threads may be counted as waiting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q       <= '0;
            first_q      <= 1'b1;
            quiet_q      <= 1'b1;
            maybe_wait_q <= '0;
            seen_q       <= '0;
        end else begin
            tick_q       <= bnd ? '0 : tick_q + KW'(1);
            first_q      <= first_q && !bnd;
            quiet_q      <= bnd ? 1'b1 : (quiet_q && maybe_wait_q == '0);
            maybe_wait_q <= (maybe_wait_q & ~wait_end_i) | wait_begin_i;
            if (acq_valid_i) seen_q[acq_tid_i] <= 1'b1;
        end
    end

    assert_hold_between_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> $stable(limiter_valid_o) && $stable(limiter_tid_o));

    assert_first_interval_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> !limiter_valid_o && limiter_tid_o == '0);

    assert_quiet_interval_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bnd && quiet_q && maybe_wait_q == '0 |=> !limiter_valid_o);

    assert_invalid_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !limiter_valid_o |-> limiter_tid_o == '0);

    assert_limiter_was_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        limiter_valid_o |-> seen_q[limiter_tid_o]);

endmodule

bind lim_limiter_id lim_limiter_id_chk #(.NT(NT), .LEN(LEN)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .wait_begin_i    (wait_begin_i),
    .wait_end_i      (wait_end_i),
    .acq_valid_i     (acq_valid_i),
    .acq_tid_i       (acq_tid_i),
    .limiter_valid_o (limiter_valid_o),
    .limiter_tid_o   (limiter_tid_o)
);

// File: tb/lim_limiter_id_tb_top.sv
module lim_limiter_id_tb_top;

    localparam int NT  = 4;
    localparam int NE  = 4;
    localparam int AW  = 16;
    localparam int LEN = 64;
    localparam int TW  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NT-1:0]     wait_begin = '0;
    logic [NT-1:0]     wait_end = '0;
    logic [NT*AW-1:0]  wait_addr = '0;
    logic              acq_valid = 1'b0;
    logic [AW-1:0]     acq_addr = '0;
    logic [TW-1:0]     acq_tid = '0;
    logic              rel_valid = 1'b0;
    logic [AW-1:0]     rel_addr = '0;
    logic              limiter_valid;
    logic [TW-1:0]     limiter_tid;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    lim_limiter_id #(.NT(NT), .NE(NE), .AW(AW), .LEN(LEN)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .wait_begin_i    (wait_begin),
        .wait_end_i      (wait_end),
        .wait_addr_i     (wait_addr),
        .acq_valid_i     (acq_valid),
        .acq_addr_i      (acq_addr),
        .acq_tid_i       (acq_tid),
        .rel_valid_i     (rel_valid),
        .rel_addr_i      (rel_addr),
        .limiter_valid_o (limiter_valid),
        .limiter_tid_o   (limiter_tid)
    );

    // ---------------- behavioural model built from the requirements
    logic          m_used [NE];
    logic          m_held [NE];
    logic [AW-1:0] m_addr [NE];
    logic [TW-1:0] m_own  [NE];
    int            m_cnt  [NE];
    logic          m_wv   [NT];
    int            m_wi   [NT];
    int            m_tick;
    logic          m_lv;
    logic [TW-1:0] m_lt;

    function automatic int find(input logic [AW-1:0] a);
        for (int e = 0; e < NE; e++) if (m_used[e] && m_addr[e] == a) return e;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NE; e++) begin
                m_used[e] = 0; m_held[e] = 0; m_addr[e] = '0; m_own[e] = '0; m_cnt[e] = 0;
            end
            for (int t = 0; t < NT; t++) begin m_wv[t] = 0; m_wi[t] = 0; end
            m_tick = 0; m_lv = 0; m_lt = '0;
        end else begin
            int  tot [NE];
            int  hidx [NT];
            logic busy [NE];
            logic freeing [NE];
            int  ai, ri, fi, best, bi;
            logic bnd;
            bnd = (m_tick == LEN - 1);
            for (int e = 0; e < NE; e++) begin
                tot[e] = m_cnt[e];
                busy[e] = 0;
                for (int t = 0; t < NT; t++) if (m_wv[t] && m_wi[t] == e) begin
                    tot[e]++; busy[e] = 1;
                end
            end
            for (int t = 0; t < NT; t++) begin
                hidx[t] = find(wait_addr[t*AW +: AW]);
                if (wait_begin[t] && hidx[t] >= 0) busy[hidx[t]] = 1;
            end
            ai = find(acq_addr);
            ri = find(rel_addr);
            fi = -1;
            for (int e = NE - 1; e >= 0; e--) if (!m_used[e]) fi = e;
            if (bnd) begin
                best = 0; bi = 0;
                for (int e = 0; e < NE; e++) if (tot[e] > best) begin best = tot[e]; bi = e; end
                m_lv = (best != 0) && m_held[bi];
                m_lt = m_lv ? m_own[bi] : '0;
            end
            for (int e = 0; e < NE; e++) begin
                freeing[e] = bnd && m_used[e] && !m_held[e] && !busy[e] && !(acq_valid && ai == e);
                m_cnt[e] = bnd ? 0 : tot[e];
            end
            for (int t = 0; t < NT; t++) begin
                if (wait_end[t]) m_wv[t] = 0;
                if (wait_begin[t] && hidx[t] >= 0) begin m_wv[t] = 1; m_wi[t] = hidx[t]; end
            end
            if (rel_valid && ri >= 0 && !(acq_valid && ai == ri)) m_held[ri] = 0;
            if (acq_valid) begin
                if (ai >= 0) begin m_held[ai] = 1; m_own[ai] = acq_tid; end
                else if (fi >= 0) begin
                    m_used[fi] = 1; m_held[fi] = 1; m_addr[fi] = acq_addr; m_own[fi] = acq_tid;
                end
            end
            for (int e = 0; e < NE; e++) if (freeing[e]) m_used[e] = 0;
            m_tick = bnd ? 0 : m_tick + 1;
        end
    end

    // ---------------- checking and driving helpers
    task automatic expect_out(input logic ev, input logic [TW-1:0] et, input string tag);
        checks++;
        if (limiter_valid !== ev || limiter_tid !== et) begin
            errors++;
            $display("FAIL %s: valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                     tag, limiter_valid, limiter_tid, ev, et);
        end
    endtask

    task automatic tick_();
        @(negedge clk);
        expect_out(m_lv, m_lt, phase);
        wait_begin = '0; wait_end = '0; acq_valid = 1'b0; rel_valid = 1'b0;
    endtask

    task automatic align();
        tick_();
        while (m_tick != 0) tick_();
    endtask

    task automatic wait_run(input int t, input logic [AW-1:0] a, input int n);
        wait_begin[t] = 1'b1;
        wait_addr[t*AW +: AW] = a;
        tick_();
        repeat (n - 1) tick_();
        wait_end[t] = 1'b1;
        tick_();
    endtask

    task automatic acquire(input logic [AW-1:0] a, input logic [TW-1:0] tid);
        acq_valid = 1'b1; acq_addr = a; acq_tid = tid;
        tick_();
    endtask

    task automatic release_lock(input logic [AW-1:0] a);
        rel_valid = 1'b1; rel_addr = a;
        tick_();
    endtask

    // ---------------- watchdog
    bit finished = 0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus
    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        expect_out(1'b0, '0, "R1 during reset");
        rst_n = 1'b1;

        // R1 / R5: first interval with no activity
        phase = "R1";
        align();
        expect_out(1'b0, '0, "R5 idle interval");

        // R2 / R6: 0x20 owned by tid3 gets 10, 0x21 owned by tid2 gets 8
        phase = "R2";
        acquire(16'h0020, 2'd3);
        acquire(16'h0021, 2'd2);
        wait_run(0, 16'h0020, 10);
        wait_run(1, 16'h0021, 4);
        wait_run(2, 16'h0021, 4);
        align();
        expect_out(1'b1, 2'd3, "R2 R6 largest total owner");

        // R7: totals cleared, nothing waits
        phase = "R7";
        align();
        expect_out(1'b0, '0, "R7 totals cleared");

        // R4: equal totals, entry 0 (owner tid3) wins
        phase = "R4";
        wait_run(0, 16'h0020, 6);
        wait_run(1, 16'h0021, 6);
        align();
        expect_out(1'b1, 2'd3, "R4 tie lowest index");

        // R6 / R9: winning lock has no owner; same-edge acquire and release
        phase = "R9";
        release_lock(16'h0020);
        acq_valid = 1'b1; acq_addr = 16'h0021; acq_tid = 2'd1;
        rel_valid = 1'b1; rel_addr = 16'h0021;
        tick_();
        wait_run(2, 16'h0020, 12);
        wait_run(0, 16'h0021, 5);
        align();
        expect_out(1'b0, '0, "R6 winner without owner");

        // R10 / R9: 0x20 freed at last end, its waits are not counted
        phase = "R10";
        wait_run(1, 16'h0020, 20);
        wait_run(0, 16'h0021, 5);
        align();
        expect_out(1'b1, 2'd1, "R10 R9 freed entry ignored, acquire beats release");

        // R8: fill the table, extra acquire and its waits are ignored
        phase = "R8";
        acquire(16'h0030, 2'd0);
        acquire(16'h0031, 2'd1);
        acquire(16'h0032, 2'd2);
        acquire(16'h0033, 2'd2);
        wait_run(0, 16'h0033, 20);
        wait_run(1, 16'h0030, 3);
        wait_run(2, 16'h0021, 2);
        align();
        expect_out(1'b1, 2'd0, "R8 full table ignores new lock");

        // R11: end and begin on one edge keeps the thread waiting
        phase = "R11";
        wait_begin[3] = 1'b1; wait_addr[3*AW +: AW] = 16'h0031;
        tick_();
        repeat (3) tick_();
        wait_end[3] = 1'b1; wait_begin[3] = 1'b1; wait_addr[3*AW +: AW] = 16'h0031;
        tick_();
        repeat (3) tick_();
        wait_end[3] = 1'b1;
        tick_();
        wait_run(0, 16'h0030, 6);
        align();
        expect_out(1'b1, 2'd1, "R11 begin wins over end");

        // random traffic compared with the model on every cycle
        phase = "R2 R3 random";
        for (int c = 0; c < 4000; c++) begin
            for (int t = 0; t < NT; t++) begin
                if (m_wv[t]) begin
                    wait_end[t] = ($urandom % 6) == 0;
                end else if (($urandom % 4) == 0) begin
                    wait_begin[t] = 1'b1;
                    wait_addr[t*AW +: AW] = 16'h0030 + AW'($urandom % 6);
                end
            end
            if (($urandom % 5) == 0) begin
                acq_valid = 1'b1;
                acq_addr  = 16'h0030 + AW'($urandom % 6);
                acq_tid   = TW'($urandom % NT);
            end
            if (($urandom % 5) == 0) begin
                rel_valid = 1'b1;
                rel_addr  = ($urandom % 7 == 0) ? 16'h0021 : 16'h0030 + AW'($urandom % 6);
            end
            tick_();
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule